// File: doc/BRIEF.md
# Clock Deskew Search Sequencer

This block is the central digital controller that walks through every leaf of a 64-leaf buffered clock tree and finds a delay setting for each one. A single lag detector at the tree centre compares each returned leaf clock with one shared delayed reference. For each leaf in turn, the sequencer starts the leaf's 7-bit capacitor-bank code at zero. It sends that code to the leaf over a two-wire serial link, waits a programmable settle time, and then samples the detector at two instants. While the leaf still lags the reference, the code goes up by one and the cycle repeats. When the detector trips, the code in use is stored as that leaf's result.

Each serial frame both selects the leaf's return path, through the address, and loads its bank, through the data. While a pass runs, the deskew-mode flag is high. Outside a pass, the serial lines rest low and the return paths stay grounded, so they act as shields. A pass can be started at boot or during any idle window, and it runs on the reduced deskew clock. After the pass, the stored code and a saturation flag for any leaf can be read back through a combinational read port.

Top module: `deskew_seq_top`

## Requirements
- R1: While reset is asserted and right after it is released, deskewMode, done, serSync and serData are all 0.
- R2: A start pulse while idle raises deskewMode on the next cycle. Leaves are then visited in address order from 0 to 63, and each leaf's first frame carries code 0.
- R3: A frame lasts 13 cycles. serSync is 1 only in the first cycle. serData carries the 6-bit leaf address MSB first, followed by the 7-bit code MSB first. Between frames and when idle, serSync and serData are 0.
- R4: Counting the cycle after a frame's last bit as 0, the detector input is sampled at T1 = cycle settleCount and at T2 = cycle settleCount+1. The lag condition holds only when the sample at T1 is 0 and the sample at T2 is 1.
- R5: While the lag condition holds and the code is below 127, the next frame starts at cycle settleCount+2 and carries the same address with the code raised by exactly one.
- R6: When the lag condition fails, the code in the last frame is stored for that leaf with the saturation flag 0, and the next leaf starts at code 0.
- R7: If the lag condition still holds with code 127, the leaf stores 127 with the saturation flag 1, and the sequencer moves on. A trip at exactly code 127 stores 127 with the flag 0.
- R8: After leaf 63 is resolved, deskewMode falls and done rises in the same cycle. done stays at 1 until the next accepted start, which clears it on the next cycle.
- R9: A start pulse while deskewMode is 1 has no effect on the running pass or on the frame sequence.
- R10: rdCode and rdSat show, combinationally, the stored code and saturation flag of the leaf selected by rdAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow deskew clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full deskew pass (ignored while busy) |
| settleCount | input | 8 | Slow cycles to wait after each frame before T1 |
| detOut | input | 1 | Lag detector output |
| rdAddr | input | 6 | Leaf whose result is read back |
| serSync | output | 1 | Serial frame-start/reset wire |
| serData | output | 1 | Serial address/code wire |
| deskewMode | output | 1 | High while a pass is running (return paths active) |
| done | output | 1 | Pass complete |
| rdCode | output | 7 | Stored code of leaf rdAddr |
| rdSat | output | 1 | Leaf rdAddr reached code 127 without a trip |

## Verification
A wrong leaf or code register shows up in the very next serial frame, because every frame carries the full address and code. A wrong step or a skipped leaf is therefore visible within 13 cycles. A wrong settle counter or sampling state moves the next sync pulse away from cycle settleCount+2, and it can also make a leaf trip too early or too late. Either way, the error appears at the next frame boundary and again in the code read back for that leaf. A wrong decision on saturation or on the end of the pass appears in rdSat, or in done and deskewMode, once the pass completes.

// File: rtl/deskew_seq_pkg.sv
package deskew_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_SETTLE,
    ST_SAMP1,
    ST_SAMP2
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrLeaf;
    logic incLeaf;
    logic clrCode;
    logic incCode;
    logic clrBit;
    logic incBit;
    logic clrSettle;
    logic incSettle;
    logic capT1;
    logic store;
    logic storeSat;
    logic sending;
  } dpStrobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic bitLast;
    logic settleZero;
    logic settleLast;
    logic codeMax;
    logic leafLast;
    logic lagHolds;
  } dpStatus_t;

endpackage

// File: rtl/deskew_seq_ctrl.sv
module deskew_seq_ctrl
  import deskew_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      deskewMode,
  output logic      done
);

  seqState_t state, nextState;
  logic      setDone, clrDone;

  always_comb begin
    strobe         = '0;
    nextState      = state;
    setDone        = 1'b0;
    clrDone        = 1'b0;
    strobe.sending = (state == ST_SEND);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clrLeaf = 1'b1;
          strobe.clrCode = 1'b1;
          strobe.clrBit  = 1'b1;
          clrDone        = 1'b1;
          nextState      = ST_SEND;
        end
      end
      ST_SEND: begin
        if (status.bitLast) begin
          strobe.clrBit    = 1'b1;
          strobe.clrSettle = 1'b1;
          nextState        = status.settleZero ? ST_SAMP1 : ST_SETTLE;
        end else begin
          strobe.incBit = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (status.settleLast) nextState = ST_SAMP1;
        else                   strobe.incSettle = 1'b1;
      end
      ST_SAMP1: begin
        strobe.capT1 = 1'b1;
        nextState    = ST_SAMP2;
      end
      ST_SAMP2: begin
        if (status.lagHolds && !status.codeMax) begin
          strobe.incCode = 1'b1;
          nextState      = ST_SEND;
        end else begin
          strobe.store    = 1'b1;
          strobe.storeSat = status.lagHolds;
          if (status.leafLast) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.incLeaf = 1'b1;
            strobe.clrCode = 1'b1;
            nextState      = ST_SEND;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (setDone)      done <= 1'b1;
      else if (clrDone) done <= 1'b0;
    end
  end

  assign deskewMode = (state != ST_IDLE);

  // R8: a finished pass leaves the FSM idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE));

  // R4: the second detector sample always follows the first
  a_r4_t2_after_t1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAMP2) |-> ($past(state) == ST_SAMP1));

endmodule

// File: rtl/deskew_seq_dp.sv
module deskew_seq_dp
  import deskew_seq_pkg::*;
#(
  parameter int LEAF_ADDR_W = 6,
  parameter int CODE_W      = 7,
  parameter int SETTLE_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [SETTLE_W-1:0]    settleCount,
  input  logic                   detOut,
  input  logic [LEAF_ADDR_W-1:0] rdAddr,
  output dpStatus_t              status,
  output logic                   serSync,
  output logic                   serData,
  output logic [CODE_W-1:0]      rdCode,
  output logic                   rdSat
);

  localparam int FRAME_W    = LEAF_ADDR_W + CODE_W;
  localparam int BIT_CNT_W  = $clog2(FRAME_W);
  localparam int NUM_LEAVES = 1 << LEAF_ADDR_W;
  localparam int ENTRY_W    = CODE_W + 1;

  logic [LEAF_ADDR_W-1:0] leafIdx;
  logic [CODE_W-1:0]      codeVal;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [SETTLE_W-1:0]    settleCnt;
  logic                   t1Sample;
  logic [FRAME_W-1:0]     frameWord;
  logic [BIT_CNT_W-1:0]   bitSel;
  logic [ENTRY_W-1:0]     rowBus [NUM_LEAVES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leafIdx   <= '0;
      codeVal   <= '0;
      bitCnt    <= '0;
      settleCnt <= '0;
      t1Sample  <= 1'b0;
    end else begin
      if (strobe.clrLeaf)      leafIdx <= '0;
      else if (strobe.incLeaf) leafIdx <= leafIdx + 1'b1;

      if (strobe.clrCode)      codeVal <= '0;
      else if (strobe.incCode) codeVal <= codeVal + 1'b1;

      if (strobe.clrBit)       bitCnt <= '0;
      else if (strobe.incBit)  bitCnt <= bitCnt + 1'b1;

      if (strobe.clrSettle)      settleCnt <= '0;
      else if (strobe.incSettle) settleCnt <= settleCnt + 1'b1;

      if (strobe.capT1) t1Sample <= detOut;
    end
  end

  // serial frame: address MSB first, then code MSB first
  assign frameWord = {leafIdx, codeVal};
  assign bitSel    = BIT_CNT_W'(FRAME_W - 1) - bitCnt;
  assign serData   = strobe.sending & frameWord[bitSel];
  assign serSync   = strobe.sending & (bitCnt == '0);

  assign status.bitLast    = (bitCnt == BIT_CNT_W'(FRAME_W - 1));
  assign status.settleZero = (settleCount == '0);
  assign status.settleLast = (settleCnt == settleCount - 1'b1);
  assign status.codeMax    = &codeVal;
  assign status.leafLast   = &leafIdx;
  assign status.lagHolds   = !t1Sample && detOut;

  // per-leaf result storage: {saturated, code}
  for (genvar g = 0; g < NUM_LEAVES; g++) begin : g_leaf
    logic [ENTRY_W-1:0] entry;
    always_ff @(posedge clk) begin
      if (!rstN) entry <= '0;
      else if (strobe.store && (leafIdx == LEAF_ADDR_W'(g)))
        entry <= {strobe.storeSat, codeVal};
    end
    assign rowBus[g] = entry;
  end

  assign rdCode = rowBus[rdAddr][CODE_W-1:0];
  assign rdSat  = rowBus[rdAddr][CODE_W];

  // R5: the code only restarts at zero or moves up by one
  a_r5_code_step: assert property (@(posedge clk) disable iff (!rstN)
    (codeVal != $past(codeVal)) |-> (codeVal == '0 || codeVal == $past(codeVal) + 1'b1));

  // R2: leaves are visited in ascending order
  a_r2_leaf_step: assert property (@(posedge clk) disable iff (!rstN)
    (leafIdx != $past(leafIdx)) |-> (leafIdx == '0 || leafIdx == $past(leafIdx) + 1'b1));

  // R3: the bit counter never runs past the frame
  a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_CNT_W'(FRAME_W - 1));

  // R7: saturation is recorded only at the top code
  a_r7_sat_at_max: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeSat |-> (&codeVal));

  // R6: a non-saturated store happens only on a detector trip
  a_r6_store_on_trip: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.store && !strobe.storeSat) |-> !status.lagHolds);

endmodule

// File: rtl/deskew_seq_top.sv
module deskew_seq_top
  import deskew_seq_pkg::*;
#(
  parameter int LEAF_ADDR_W = 6,
  parameter int CODE_W      = 7,
  parameter int SETTLE_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [SETTLE_W-1:0]    settleCount,
  input  logic                   detOut,
  input  logic [LEAF_ADDR_W-1:0] rdAddr,
  output logic                   serSync,
  output logic                   serData,
  output logic                   deskewMode,
  output logic                   done,
  output logic [CODE_W-1:0]      rdCode,
  output logic                   rdSat
);

  dpStrobe_t strobe;
  dpStatus_t status;

  deskew_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .status     (status),
    .strobe     (strobe),
    .deskewMode (deskewMode),
    .done       (done)
  );

  deskew_seq_dp #(
    .LEAF_ADDR_W (LEAF_ADDR_W),
    .CODE_W      (CODE_W),
    .SETTLE_W    (SETTLE_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .settleCount (settleCount),
    .detOut      (detOut),
    .rdAddr      (rdAddr),
    .status      (status),
    .serSync     (serSync),
    .serData     (serData),
    .rdCode      (rdCode),
    .rdSat       (rdSat)
  );

endmodule

// File: tb/deskew_seq_top_tb_top.sv
module deskew_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN, start, detOut;
  logic [7:0] settleCount;
  logic [5:0] rdAddr;
  logic       serSync, serData, deskewMode, done, rdSat;
  logic [6:0] rdCode;

  int errCnt = 0;
  int chkCnt = 0;
  int thr [64];
  int settleCfg = 0;
  int expLeaf = 0;
  int expCode = 0;

  always #10 clk = ~clk;

  deskew_seq_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .settleCount(settleCount),
    .detOut(detOut), .rdAddr(rdAddr), .serSync(serSync), .serData(serData),
    .deskewMode(deskewMode), .done(done), .rdCode(rdCode), .rdSat(rdSat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCodeOf(input int t);
    return (t > 127) ? 127 : t;
  endfunction

  function automatic int expSatOf(input int t);
    return (t > 127) ? 1 : 0;
  endfunction

  // decodes frames at the ports and plays the lag detector
  task automatic detectorModel();
    int bitIdx = 0;
    int k = 0;
    bit armed = 0;
    bit pat = 0;
    logic [12:0] sh = '0;
    int curA = 0;
    int curC = 0;
    forever begin
      @(negedge clk);
      if (serSync) begin
        if (bitIdx != 0) check(0, "R3 sync inside frame", bitIdx, 0);
        if (armed) check(k == settleCfg + 2, "R5 frame gap", k, settleCfg + 2);
        else if (expCode != 0) check(0, "R5 late frame", k, settleCfg + 2);
        armed = 0;
        sh = {12'b0, serData};
        bitIdx = 1;
        detOut = 1'b0;
      end else if (bitIdx > 0) begin
        sh = {sh[11:0], serData};
        bitIdx++;
        if (bitIdx == 13) begin
          curA = int'(sh[12:7]);
          curC = int'(sh[6:0]);
          bitIdx = 0;
          armed = 1;
          k = 0;
          pat = 1'($urandom_range(0, 1));
          check(curA == expLeaf, "R2 leaf order", curA, expLeaf);
          check(curC == expCode, "R5 code step", curC, expCode);
          if (curC >= thr[curA] || curC == 127) begin
            expLeaf++;
            expCode = 0;
          end else begin
            expCode++;
          end
        end
      end else if (armed) begin
        if (serData) check(0, "R3 idle data", 1, 0);
        // lag: low at T1, high at T2; trip patterns: always high or always low
        if (curC < thr[curA]) detOut = (k >= settleCfg + 1);
        else                  detOut = pat;
        k++;
        if (k > settleCfg + 2) armed = 0;
      end
    end
  endtask

  task automatic runPass(input int s, input int variant);
    int cyc = 0;
    settleCfg = s;
    settleCount = 8'(s);
    for (int l = 0; l < 64; l++) thr[l] = $urandom_range(0, 30);
    if (variant == 0) begin
      thr[0] = 0; thr[5] = 127; thr[9] = 300; thr[63] = 128;
    end else begin
      thr[1] = 500; thr[63] = 127; thr[62] = 0;
    end
    expLeaf = 0;
    expCode = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(deskewMode == 1'b1, "R2 mode after start", deskewMode, 1);
    check(done == 1'b0, "R8 done cleared by start", done, 0);
    while (!done && cyc < 90000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 500) start = 1'b1;
      if (cyc == 501) begin
        start = 1'b0;
        check(deskewMode == 1'b1, "R9 busy start ignored", deskewMode, 1);
      end
    end
    check(done == 1'b1, "R8 pass completes", done, 1);
    check(deskewMode == 1'b0, "R8 mode low at done", deskewMode, 0);
    check(expLeaf == 64, "R2 all leaves visited", expLeaf, 64);
    repeat (5) begin
      @(negedge clk);
      check(serSync == 1'b0 && serData == 1'b0, "R3 lines idle after pass",
            int'({serSync, serData}), 0);
      check(done == 1'b1, "R8 done held", done, 1);
    end
    for (int l = 0; l < 64; l++) begin
      rdAddr = 6'(l);
      #1;
      check(int'(rdCode) == expCodeOf(thr[l]), "R6 R10 stored code", int'(rdCode), expCodeOf(thr[l]));
      check(int'(rdSat) == expSatOf(thr[l]), "R7 R10 saturation flag", int'(rdSat), expSatOf(thr[l]));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0;
    start = 1'b0;
    detOut = 1'b0;
    settleCount = 8'd0;
    rdAddr = 6'd0;
    fork
      detectorModel();
    join_none
    repeat (3) @(negedge clk);
    check({deskewMode, done, serSync, serData} == 4'b0, "R1 outputs in reset",
          int'({deskewMode, done, serSync, serData}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({deskewMode, done, serSync, serData} == 4'b0, "R1 outputs after reset",
          int'({deskewMode, done, serSync, serData}), 0);
    runPass(3, 0);
    runPass(0, 1);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule